// File: doc/BRIEF.md
# Burst-Capable External Bus Master

This block owns a synchronous external bus and turns requests from an internal port into bus cycles. A request carries an address, a direction, a byte count and a burst flag. The block accepts it only while the bus is idle. It opens the cycle with a one-clock start strobe and holds the address, size code, direction and burst flag stable until the slave has closed every data beat with its acknowledge. At the end it pulses a done signal.

A single transfer moves one 32-bit beat. A burst moves four. During a burst a data-in-progress line stays low while more beats are still to come. It goes high once the third beat is acknowledged, which tells the slave that the beat now on the bus is the last one. Read data is captured from the bus on each acknowledging edge and returned as a four-word vector. Write data is latched at acceptance and placed on the bus one word per beat.

Top module: `ext_bus_master`

## Requirements
- R1: After reset, and whenever no transaction is in progress, the bus outputs are at rest: `bus_own_o`=0, `bus_ts_no`=1, `bus_burst_no`=1, `bus_bdip_no`=1, `bus_rd_wr_o`=1, `bus_addr_o`=0, `bus_tsiz_o`=00 and `bus_dat_o`=0. On the request side, `req_ready_o`=1 and `done_o`=0.
- R2: A request is accepted on a rising edge where `req_valid_i` and `req_ready_o` are both 1. In the next cycle `bus_own_o` rises and `bus_ts_no` is 0 for exactly that one cycle.
- R3: From the start cycle until the final acknowledge edge, `bus_addr_o` equals the accepted address. `bus_rd_wr_o` is 1 for a read and 0 for a write. `bus_burst_no` is 0 for a burst and 1 for a single transfer. All of these stay stable.
- R4: `bus_tsiz_o` encodes the accepted byte count `req_nbytes_i` as 1→01, 2→10, 3→11 and 4→00. Any other count gives 00. A burst always gives 00.
- R5: A single transfer ends at its first acknowledge, which is `bus_ta_ni`=0 at a rising edge. A burst ends at its fourth. Wait cycles with `bus_ta_ni`=1 may come before any beat.
- R6: During a burst, `bus_bdip_no` is 0 from the start cycle through the edge that acknowledges the third beat, and 1 during the fourth beat. It is never 0 during a single transfer.
- R7: On a write, beat k drives `bus_dat_o` with `req_wdata_i[32k+31:32k]` as latched at acceptance. A single write uses word 0.
- R8: On a read, the `bus_dat_i` value sampled at the acknowledge edge of beat k appears in `rd_data_o[32k+31:32k]` by the time `done_o` is 1.
- R9: `done_o` is 1 for exactly one cycle, the cycle after the final acknowledge edge. In that same cycle `bus_own_o` is 0 and the bus outputs are back at rest.
- R10: While a transaction is in progress, `req_ready_o` is 0. Requests presented during that time have no effect on the bus outputs, and no transaction starts from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Bus idle, request can be accepted |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_burst_i | input | 1 | 1 = four-beat burst |
| req_nbytes_i | input | 3 | Byte count of a single transfer (1..4) |
| req_addr_i | input | 26 | Bus address |
| req_wdata_i | input | 128 | Write words, word k for beat k |
| rd_data_o | output | 128 | Read words, word k from beat k |
| done_o | output | 1 | One-cycle completion pulse |
| bus_own_o | output | 1 | Block is bus owner and outputs are driven |
| bus_addr_o | output | 26 | Address |
| bus_tsiz_o | output | 2 | Transfer-size code |
| bus_rd_wr_o | output | 1 | 1 = read, 0 = write |
| bus_ts_no | output | 1 | Transfer start, active low |
| bus_burst_no | output | 1 | Burst cycle, active low |
| bus_bdip_no | output | 1 | Burst data in progress, active low |
| bus_dat_o | output | 32 | Write data |
| bus_dat_i | input | 32 | Read data |
| bus_ta_ni | input | 1 | Transfer acknowledge, active low |

## Verification
The beat counter is the one piece of state that the ports do not show directly. If it slips, it shows up at the ports right away. A miscount ends a burst one beat early or late, so `done_o` lands on the wrong cycle. A stale index puts the wrong write word on `bus_dat_o` in that same beat. A fault in the data-in-progress line shows as a wrong level at the negedge just before each acknowledge. A control state stuck outside idle shows in the next cycle as `req_ready_o` low or `bus_ts_no` held low for longer than one clock.

// File: rtl/ebm_pkg.sv
package ebm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA} ebm_state_e;

  // byte count to size code; 4 wraps to 00, anything unsupported maps to 00
  function automatic logic [1:0] tsiz_enc(input logic [2:0] nbytes);
    case (nbytes)
      3'd1:    tsiz_enc = 2'b01;
      3'd2:    tsiz_enc = 2'b10;
      3'd3:    tsiz_enc = 2'b11;
      default: tsiz_enc = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/ebm_ctl.sv
module ebm_ctl
  import ebm_pkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_burst_i,
  input  logic [2:0]        req_nbytes_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              last_ack_i,
  output logic              req_ready_o,
  output logic              accept_o,
  output logic              own_o,
  output logic              start_o,
  output logic              write_o,
  output logic              burst_o,
  output logic [1:0]        tsiz_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  ebm_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        tsiz_q;
  logic              write_q, burst_q, done_q;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept_o    = req_ready_o && req_valid_i;
  assign own_o       = (state_q != ST_IDLE);
  assign start_o     = (state_q == ST_START);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept_o)   state_d = ST_START;
      ST_START: state_d = last_ack_i ? ST_IDLE : ST_DATA;
      ST_DATA:  if (last_ack_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      tsiz_q  <= '0;
      write_q <= 1'b0;
      burst_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= own_o && last_ack_i;
      if (accept_o) begin
        addr_q  <= req_addr_i;
        write_q <= req_write_i;
        burst_q <= req_burst_i;
        tsiz_q  <= req_burst_i ? 2'b00 : tsiz_enc(req_nbytes_i);
      end
    end
  end

  // bus-facing values are forced to rest while not owning
  assign addr_o  = own_o ? addr_q : '0;
  assign tsiz_o  = own_o ? tsiz_q : 2'b00;
  assign write_o = own_o && write_q;
  assign burst_o = own_o && burst_q;
  assign done_o  = done_q;

  assert_ready_only_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !own_o) else $error("ready while owning");
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("done longer than one cycle");
  assert_done_after_own_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!own_o && $past(own_o))) else $error("done without ending cycle");
  assert_start_after_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> start_o) else $error("no start after accept");
endmodule

// File: rtl/ebm_beat.sv
module ebm_beat #(
  parameter int BURST_LEN = 4,
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              own_i,
  input  logic              burst_i,
  input  logic              ack_i,
  output logic [BEAT_W-1:0] beat_o,
  output logic              last_ack_o,
  output logic              bdip_o
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  logic [BEAT_W-1:0] beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       beat_q <= '0;
    else if (accept_i) beat_q <= '0;
    else if (ack_i && !last_ack_o) beat_q <= beat_q + 1'b1;
  end

  assign beat_o     = beat_q;
  assign last_ack_o = ack_i && (!burst_i || beat_q == LAST_BEAT);
  // more beats still expected after the present one
  assign bdip_o     = own_i && burst_i && (beat_q != LAST_BEAT);

  assert_beat_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_i && !burst_i) |-> (beat_q == '0)) else $error("single moved beat index");
  assert_bdip_burst_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bdip_o |-> burst_i) else $error("bdip outside burst");
  assert_bdip_drops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && bdip_o && beat_q == LAST_BEAT - 1'b1) |=> !bdip_o)
    else $error("bdip not released before last beat");
endmodule

// File: rtl/ebm_rdcap.sv
module ebm_rdcap #(
  parameter int DATA_W    = 32,
  parameter int BURST_LEN = 4,
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          ack_i,
  input  logic                          write_i,
  input  logic [BEAT_W-1:0]             beat_i,
  input  logic [DATA_W-1:0]             dat_i,
  output logic [BURST_LEN*DATA_W-1:0]   rdata_o
);
  for (genvar g = 0; g < BURST_LEN; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        rdata_o[g*DATA_W +: DATA_W] <= '0;
      else if (ack_i && !write_i && beat_i == BEAT_W'(g))
        rdata_o[g*DATA_W +: DATA_W] <= dat_i;
    end
  end
endmodule

// File: rtl/ext_bus_master.sv
module ext_bus_master #(
  parameter int ADDR_W    = 26,
  parameter int DATA_W    = 32,
  parameter int BURST_LEN = 4,
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1,
  localparam int LINE_W = BURST_LEN * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic              req_burst_i,
  input  logic [2:0]        req_nbytes_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LINE_W-1:0] req_wdata_i,
  output logic [LINE_W-1:0] rd_data_o,
  output logic              done_o,
  output logic              bus_own_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [1:0]        bus_tsiz_o,
  output logic              bus_rd_wr_o,
  output logic              bus_ts_no,
  output logic              bus_burst_no,
  output logic              bus_bdip_no,
  output logic [DATA_W-1:0] bus_dat_o,
  input  logic [DATA_W-1:0] bus_dat_i,
  input  logic              bus_ta_ni
);
  logic              accept, own, start, write, burst, ack, last_ack, bdip;
  logic [BEAT_W-1:0] beat;
  logic [LINE_W-1:0] wdata_q;

  assign ack = own && !bus_ta_ni;

  ebm_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_write_i, .req_burst_i, .req_nbytes_i, .req_addr_i,
    .last_ack_i (last_ack),
    .req_ready_o,
    .accept_o   (accept),
    .own_o      (own),
    .start_o    (start),
    .write_o    (write),
    .burst_o    (burst),
    .tsiz_o     (bus_tsiz_o),
    .addr_o     (bus_addr_o),
    .done_o
  );

  ebm_beat #(.BURST_LEN(BURST_LEN)) u_beat (
    .clk_i, .rst_ni,
    .accept_i   (accept),
    .own_i      (own),
    .burst_i    (burst),
    .ack_i      (ack),
    .beat_o     (beat),
    .last_ack_o (last_ack),
    .bdip_o     (bdip)
  );

  ebm_rdcap #(.DATA_W(DATA_W), .BURST_LEN(BURST_LEN)) u_rdcap (
    .clk_i, .rst_ni,
    .ack_i   (ack),
    .write_i (write),
    .beat_i  (beat),
    .dat_i   (bus_dat_i),
    .rdata_o (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wdata_q <= '0;
    else if (accept) wdata_q <= req_wdata_i;
  end

  assign bus_own_o    = own;
  assign bus_rd_wr_o  = !write;
  assign bus_ts_no    = !start;
  assign bus_burst_no = !burst;
  assign bus_bdip_no  = !bdip;
  assign bus_dat_o    = write ? wdata_q[beat*DATA_W +: DATA_W] : '0;

  assert_ts_one_clk_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_ts_no |=> bus_ts_no) else $error("ts longer than one clock");
  assert_ts_owned_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_ts_no |-> bus_own_o) else $error("ts without ownership");
  assert_addr_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_own_o && bus_ts_no) |-> ($stable(bus_addr_o) && $stable(bus_rd_wr_o)
                                  && $stable(bus_tsiz_o) && $stable(bus_burst_no)))
    else $error("attributes changed mid-cycle");
  assert_burst_tsiz_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_burst_no |-> (bus_tsiz_o == 2'b00)) else $error("burst size not 00");
  assert_rest_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_own_o |-> (bus_ts_no && bus_burst_no && bus_bdip_no && bus_rd_wr_o
                    && bus_addr_o == '0)) else $error("outputs not at rest");
endmodule

// File: tb/tb_ext_bus_master.sv
module tb_ext_bus_master;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;

  typedef struct packed {
    logic        write;
    logic        burst;
    logic [2:0]  nbytes;
    logic [25:0] addr;
    logic [1:0]  tsiz;
    logic [1:0]  waits;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 3'd4, 26'h0000100, 2'b00, 2'd0},
    '{1'b1, 1'b0, 3'd1, 26'h3FFFFFF, 2'b01, 2'd1},
    '{1'b0, 1'b0, 3'd2, 26'h1234567, 2'b10, 2'd2},
    '{1'b1, 1'b0, 3'd3, 26'h2AAAAAA, 2'b11, 2'd0},
    '{1'b0, 1'b1, 3'd1, 26'h0000040, 2'b00, 2'd0},
    '{1'b1, 1'b1, 3'd2, 26'h1555550, 2'b00, 2'd1},
    '{1'b0, 1'b0, 3'd0, 26'h0ABCDEF, 2'b00, 2'd0},
    '{1'b1, 1'b0, 3'd7, 26'h0000004, 2'b00, 2'd3},
    '{1'b0, 1'b1, 3'd4, 26'h3000000, 2'b00, 2'd3}
  };

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
  logic [2:0]   req_nbytes = '0;
  logic [25:0]  req_addr = '0;
  logic [127:0] req_wdata = '0;
  logic [31:0]  bus_dat_i = '0;
  logic         bus_ta_n = 1'b1;
  logic         req_ready, done, own, rd_wr, ts_n, burst_n, bdip_n;
  logic [127:0] rd_data;
  logic [25:0]  addr;
  logic [1:0]   tsiz;
  logic [31:0]  bus_dat_o;
  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_bus_master dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_burst_i(req_burst), .req_nbytes_i(req_nbytes), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .rd_data_o(rd_data), .done_o(done),
    .bus_own_o(own), .bus_addr_o(addr), .bus_tsiz_o(tsiz), .bus_rd_wr_o(rd_wr),
    .bus_ts_no(ts_n), .bus_burst_no(burst_n), .bus_bdip_no(bdip_n),
    .bus_dat_o(bus_dat_o), .bus_dat_i(bus_dat_i), .bus_ta_ni(bus_ta_n)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wword(input int idx, input int k);
    return 32'hA000_0000 | (idx << 8) | k;
  endfunction
  function automatic logic [31:0] rword(input int idx, input int k);
    return 32'h5000_0000 | (idx << 8) | k;
  endfunction

  task automatic chk_rest(input string tag);
    chk({tag, " R1 rest"}, {own, ts_n, burst_n, bdip_n, rd_wr, addr, tsiz, bus_dat_o},
        {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 26'h0, 2'b00, 32'h0});
  endtask

  task automatic run_txn(input int idx, input vec_t v);
    int   nbeats;
    logic first;
    nbeats = v.burst ? 4 : 1;
    @(negedge clk);
    req_valid = 1'b1; req_write = v.write; req_burst = v.burst;
    req_nbytes = v.nbytes; req_addr = v.addr;
    for (int k = 0; k < 4; k++) req_wdata[32*k +: 32] = wword(idx, k);
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~v.addr; req_wdata = '1;
    first = 1'b1;
    for (int b = 0; b < nbeats; b++) begin
      for (int w = 0; w <= int'(v.waits); w++) begin
        chk("R2 ts/own", {ts_n, own}, {!first, 1'b1});
        chk("R10 ready low", req_ready, 1'b0);
        chk("R3 attrs", {addr, rd_wr, burst_n}, {v.addr, !v.write, !v.burst});
        chk("R4 tsiz", tsiz, v.tsiz);
        chk("R6 bdip", bdip_n, !(v.burst && b <= 2));
        chk("R5 no early done", done, 1'b0);
        if (v.write) chk("R7 wdata", bus_dat_o, wword(idx, b));
        if (w == int'(v.waits)) begin
          bus_ta_n = 1'b0;
          bus_dat_i = rword(idx, b);
        end
        @(negedge clk);
        bus_ta_n = 1'b1;
        bus_dat_i = 32'hDEAD_BEEF;
        first = 1'b0;
      end
    end
    chk("R9 done pulse", {done, req_ready}, 2'b11);
    chk_rest("R9");
    if (!v.write)
      for (int k = 0; k < nbeats; k++) chk("R8 rdata", rd_data[32*k +: 32], rword(idx, k));
    @(negedge clk);
    chk("R9 done single cycle", done, 1'b0);
    chk_rest("R9 after");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset done/ready", {done, req_ready}, 2'b01);
    chk_rest("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_rest("R1 post reset");

    for (int i = 0; i < NVEC; i++) run_txn(i, VECS[i]);

    // R10: a request presented mid-transaction must not take effect
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_burst = 1'b0;
    req_nbytes = 3'd2; req_addr = 26'h0111111;
    @(negedge clk);
    req_addr = 26'h2222222; req_write = 1'b1; req_burst = 1'b1;
    chk("R10 ready busy", req_ready, 1'b0);
    repeat (2) begin
      @(negedge clk);
      chk("R10 attrs kept", {addr, rd_wr, burst_n, tsiz}, {26'h0111111, 1'b1, 1'b1, 2'b10});
      chk("R2 ts not reissued", ts_n, 1'b1);
    end
    req_valid = 1'b0;
    bus_ta_n = 1'b0; bus_dat_i = 32'h1234_ABCD;
    @(negedge clk);
    bus_ta_n = 1'b1;
    chk("R9 done after busy test", done, 1'b1);
    chk("R8 rdata busy test", rd_data[31:0], 32'h1234_ABCD);
    repeat (3) begin
      @(negedge clk);
      chk_rest("R10 no stray start");
      chk("R10 no done", done, 1'b0);
    end

    // R5: acknowledge while idle has no effect
    bus_ta_n = 1'b0;
    @(negedge clk);
    bus_ta_n = 1'b1;
    chk("R5 idle ack ignored", {done, own}, 2'b00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule